// File: doc/BRIEF.md
# Chainable Reloadable Event Counter Pair

This block holds two 16-bit down-counters. Each counter has its own 32-bit control word. The control word picks the resource that makes the counter step down, and a second resource that loads it from a programmed reload value. Each of these two choices is either one of 16 single resource lines or one of 8 resource pairs that have already been combined outside the block. A counter can also reload itself when it is at zero and its count resource fires.

Counter 1 can be chained to counter 0. In that mode every reload of counter 0 also steps counter 1 down, so the two counters act as one wider counter. Software sets the control, reload and value registers through a simple write port and reads them back through a combinational read port. Each counter drives its value, a one-cycle reload pulse and an at-zero flag.

Each counter is a two-state machine. LIVE means the value is non-zero. ZERO means the value is zero. The transition LIVE→ZERO is taken when a decrement from 1 or a write of 0 happens. ZERO→LIVE is taken on a reload of a non-zero value or a non-zero write. LIVE→LIVE covers steps that leave the value non-zero. ZERO→ZERO covers the hold at zero when nothing reloads the counter.

Top module: `evt_cnt_pair`

## Requirements
- R1: A control word reads back with only bits [3:0] (count select), 7 (count pair mode), [11:8] (reload select), 15 (reload pair mode), 16 (self-reload) and 17 (chain) kept. Every other bit reads as 0. Register addresses are {counter, reg} with reg 0 = control, 1 = reload value, 2 = counter value. A counter or reload value reads in bits [15:0] with zeros above.
- R2: With a pair-mode bit of 0, the matching 4-bit select picks single resource line sel (0..15).
- R3: With a pair-mode bit of 1, only the low 3 bits of the select are used, and they pick pair line sel[2:0]. Single lines are then ignored for that choice.
- R4: Each cycle in which the count condition holds, a non-zero counter steps down by exactly 1. It steps down by 1 even when both the count resource and the chain input are active.
- R5: The chosen reload resource always loads the reload value into the counter, whatever the self-reload bit is. The counter's reload pulse output is 1 in the cycle after a reload, and only then.
- R6: When self-reload is 1 and the value is 0 while the count resource is active, the counter reloads and pulses. When self-reload is 0, the counter does not reload in that case.
- R7: When a reload and a decrement fall in the same cycle, the reload wins.
- R8: A counter at zero that is not reloaded stays at zero and does not wrap. Its at-zero flag is 1 exactly when its value is 0.
- R9: When counter 1's chain bit is 1, each reload of counter 0 steps counter 1 down. When the chain bit is 0, counter 0's reloads have no effect on counter 1. Counter 0's chain bit has no effect.
- R10: A write to a counter value register loads that value at the next edge. It overrides any count or reload in the same cycle.
- R11: After reset, all registers are 0, both at-zero flags are 1 and both reload pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_res_i | input | 16 | Single resource lines |
| pair_res_i | input | 8 | Pre-combined resource pair lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address {counter, reg[1:0]} |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i (combinational) |
| value0_o | output | 16 | Counter 0 value |
| value1_o | output | 16 | Counter 1 value |
| reload_o | output | 2 | Per-counter reload pulse, one cycle after the reload |
| at_zero_o | output | 2 | Per-counter at-zero flag |

## Verification
The counter value is visible at the ports in every cycle. A wrong decrement, a missed reload or a lost priority therefore shows on value0_o or value1_o one edge after the stimulus. A FSM state that disagrees with the value shows on at_zero_o in that same cycle. A wrong chain connection shows only at counter 1's value, one edge after counter 0's reload. For that reason the bench reads counter 1 right after each counter-0 reload, with the chain bit set and with it clear.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
    localparam int CTRL_W = 32;
    localparam logic [CTRL_W-1:0] CTRL_MASK = 32'h0003_8F8F;
    localparam int B_CSEL  = 0;
    localparam int B_CPAIR = 7;
    localparam int B_RSEL  = 8;
    localparam int B_RPAIR = 15;
    localparam int B_SELF  = 16;
    localparam int B_CHAIN = 17;

    typedef enum logic { CNT_LIVE = 1'b0, CNT_ZERO = 1'b1 } cnt_state_e;
    typedef enum logic [1:0] { REG_CTRL = 2'd0, REG_RLD = 2'd1, REG_VAL = 2'd2, REG_NONE = 2'd3 } reg_sel_e;
endpackage

// File: rtl/evt_res_sel.sv
module evt_res_sel #(
    parameter int N_SINGLE = 16,
    parameter int N_PAIR   = 8,
    localparam int SEL_W   = $clog2(N_SINGLE),
    localparam int PAIR_W  = $clog2(N_PAIR)
) (
    input  logic [N_SINGLE-1:0] single_i,
    input  logic [N_PAIR-1:0]   pair_i,
    input  logic                pair_mode_i,
    input  logic [SEL_W-1:0]    sel_i,
    output logic                hit_o
);
    always_comb begin
        if (pair_mode_i) hit_o = pair_i[sel_i[PAIR_W-1:0]];
        else             hit_o = single_i[sel_i];
    end
endmodule

// File: rtl/evt_cnt_slice.sv
module evt_cnt_slice
    import evt_cnt_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int N_SINGLE  = 16,
    parameter int N_PAIR    = 8,
    parameter bit HAS_CHAIN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SINGLE-1:0] single_i,
    input  logic [N_PAIR-1:0]   pair_i,
    input  logic                chain_i,
    input  logic                wr_ctrl_i,
    input  logic                wr_rld_i,
    input  logic                wr_val_i,
    input  logic [CTRL_W-1:0]   wr_data_i,
    output logic [CTRL_W-1:0]   ctrl_o,
    output logic [CNT_W-1:0]    rld_val_o,
    output logic [CNT_W-1:0]    value_o,
    output logic                reload_now_o,
    output logic                reload_pulse_o,
    output logic                at_zero_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  rld_q, value_q, value_d;
    logic              cnt_hit, rld_hit, chain_en, dec, pulse_q;
    cnt_state_e        state_q, state_d;

    evt_res_sel #(.N_SINGLE(N_SINGLE), .N_PAIR(N_PAIR)) u_cnt_sel (
        .single_i(single_i), .pair_i(pair_i),
        .pair_mode_i(ctrl_q[B_CPAIR]), .sel_i(ctrl_q[B_CSEL +: 4]), .hit_o(cnt_hit));

    evt_res_sel #(.N_SINGLE(N_SINGLE), .N_PAIR(N_PAIR)) u_rld_sel (
        .single_i(single_i), .pair_i(pair_i),
        .pair_mode_i(ctrl_q[B_RPAIR]), .sel_i(ctrl_q[B_RSEL +: 4]), .hit_o(rld_hit));

    generate
        if (HAS_CHAIN) begin : g_chain
            assign chain_en = ctrl_q[B_CHAIN] & chain_i;
        end else begin : g_nochain
            assign chain_en = 1'b0;
        end
    endgenerate

    assign dec          = cnt_hit | chain_en;
    assign reload_now_o = !wr_val_i &&
                          (rld_hit || (ctrl_q[B_SELF] && cnt_hit && state_q == CNT_ZERO));

    always_comb begin
        value_d = value_q;
        if (wr_val_i)                        value_d = wr_data_i[CNT_W-1:0];
        else if (reload_now_o)               value_d = rld_q;
        else if (dec && state_q == CNT_LIVE) value_d = value_q - CNT_W'(1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_LIVE: if (value_d == '0) state_d = CNT_ZERO;
            CNT_ZERO: if (value_d != '0) state_d = CNT_LIVE;
            default:  state_d = CNT_ZERO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CNT_ZERO;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            rld_q   <= '0;
            value_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            if (wr_ctrl_i) ctrl_q <= wr_data_i & CTRL_MASK;
            if (wr_rld_i)  rld_q  <= wr_data_i[CNT_W-1:0];
            value_q <= value_d;
            pulse_q <= reload_now_o;
        end
    end

    always_comb begin
        ctrl_o         = ctrl_q;
        rld_val_o      = rld_q;
        value_o        = value_q;
        reload_pulse_o = pulse_q;
        at_zero_o      = (state_q == CNT_ZERO);
    end

    p_dec_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_val_i && !reload_now_o && dec && value_q != '0) |=> value_q == $past(value_q) - CNT_W'(1));
    p_reload_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reload_now_o |=> (value_q == $past(rld_q)) && reload_pulse_o);
    p_hold_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (value_q == '0 && !reload_now_o && !wr_val_i) |=> value_q == '0);
    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        at_zero_o == (value_q == '0));
    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_val_i |=> value_q == $past(wr_data_i[CNT_W-1:0]) && !reload_pulse_o);
endmodule

// File: rtl/evt_cnt_pair.sv
module evt_cnt_pair
    import evt_cnt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int N_SINGLE = 16,
    parameter int N_PAIR   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SINGLE-1:0] single_res_i,
    input  logic [N_PAIR-1:0]   pair_res_i,
    input  logic                wr_en_i,
    input  logic [2:0]          addr_i,
    input  logic [CTRL_W-1:0]   wr_data_i,
    output logic [CTRL_W-1:0]   rd_data_o,
    output logic [CNT_W-1:0]    value0_o,
    output logic [CNT_W-1:0]    value1_o,
    output logic [1:0]          reload_o,
    output logic [1:0]          at_zero_o
);
    localparam int N_CNT = 2;

    logic [CTRL_W-1:0] ctrl   [N_CNT];
    logic [CNT_W-1:0]  rldv   [N_CNT];
    logic [CNT_W-1:0]  val    [N_CNT];
    logic [N_CNT-1:0]  rld_now;
    reg_sel_e          rsel;

    assign rsel = reg_sel_e'(addr_i[1:0]);

    generate
        for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
            logic hit, chain_in;
            assign hit      = wr_en_i && (addr_i[2] == i[0]);
            assign chain_in = (i == 0) ? 1'b0 : rld_now[(i == 0) ? 0 : i-1];
            evt_cnt_slice #(
                .CNT_W(CNT_W), .N_SINGLE(N_SINGLE), .N_PAIR(N_PAIR), .HAS_CHAIN(i != 0)
            ) u_slice (
                .clk(clk), .rst_n(rst_n),
                .single_i(single_res_i), .pair_i(pair_res_i), .chain_i(chain_in),
                .wr_ctrl_i(hit && rsel == REG_CTRL),
                .wr_rld_i (hit && rsel == REG_RLD),
                .wr_val_i (hit && rsel == REG_VAL),
                .wr_data_i(wr_data_i),
                .ctrl_o(ctrl[i]), .rld_val_o(rldv[i]), .value_o(val[i]),
                .reload_now_o(rld_now[i]), .reload_pulse_o(reload_o[i]),
                .at_zero_o(at_zero_o[i]));
        end
    endgenerate

    always_comb begin
        rd_data_o = '0;
        unique case (rsel)
            REG_CTRL: rd_data_o = ctrl[addr_i[2]];
            REG_RLD:  rd_data_o = {{(CTRL_W-CNT_W){1'b0}}, rldv[addr_i[2]]};
            REG_VAL:  rd_data_o = {{(CTRL_W-CNT_W){1'b0}}, val[addr_i[2]]};
            REG_NONE: rd_data_o = '0;
        endcase
    end

    assign value0_o = val[0];
    assign value1_o = val[1];

    p_chain_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_now[0] && ctrl[1][B_CHAIN] && !rld_now[1] && val[1] != '0 &&
         !(wr_en_i && addr_i == 3'd6)) |=> value1_o == $past(val[1]) - CNT_W'(1));
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == REG_CTRL) |-> (rd_data_o & ~CTRL_MASK) == '0);
endmodule

// File: tb/evt_cnt_pair_tb.sv
module evt_cnt_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] single_res_i = '0;
    logic [7:0]  pair_res_i = '0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_o;
    logic [15:0] value0_o, value1_o;
    logic [1:0]  reload_o, at_zero_o;

    typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
    item_t sb[$];
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    evt_cnt_pair u_dut (.*);

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it; it.kind = kind; it.exp = exp; it.tag = tag; sb.push_back(it);
    endtask

    task automatic drive(input logic [15:0] s, input logic [7:0] p, input logic [2:0] a);
        @(negedge clk);
        wr_en_i = 1'b0; single_res_i = s; pair_res_i = p; addr_i = a;
    endtask

    task automatic wrt(input logic [2:0] a, input logic [31:0] d, input logic [15:0] s);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wr_data_i = d; single_res_i = s; pair_res_i = '0;
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk); #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0: act = {16'b0, value0_o};
                    1: act = {16'b0, value1_o};
                    2: act = {30'b0, at_zero_o};
                    3: act = {30'b0, reload_o};
                    default: act = rd_data_o;
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push(0, 0, "R11 value0"); push(1, 0, "R11 value1");
        push(2, 2'b11, "R11 at_zero"); push(3, 0, "R11 reload"); push(4, 0, "R11 ctrl0");
        // R1 reserved bits
        wrt(0, 32'hFFFF_FFFF, 0);
        drive(0, 0, 0); push(4, 32'h0003_8F8F, "R1 ctrl mask");
        // R2/R4 single select 5
        wrt(0, 32'h5, 0); wrt(1, 3, 0); wrt(2, 4, 0); push(0, 4, "R10 load value");
        drive(16'h0020, 0, 2); push(0, 3, "R2 R4 step"); push(4, 3, "R1 value readback");
        drive(16'h0010, 0, 0); push(0, 3, "R2 other line ignored");
        drive(16'h0020, 0, 0); push(0, 2, "R4 step");
        drive(16'h0020, 0, 0); push(0, 1, "R4 step");
        drive(16'h0020, 0, 0); push(0, 0, "R4 to zero"); push(2, 2'b11, "R8 flag");
        drive(16'h0020, 0, 0); push(0, 0, "R8 hold"); push(3, 0, "R6 no self reload");
        // R3 pair select, sel=0xB -> pair 3
        wrt(0, 32'h8B, 0); wrt(2, 2, 0);
        drive(0, 8'h08, 0); push(0, 1, "R3 pair step"); push(2, 2'b10, "R8 flag clear");
        drive(16'h0800, 0, 0); push(0, 1, "R3 single ignored");
        // R5/R7 reload on single 2 while counting
        wrt(0, 32'h205, 0);
        drive(16'h0024, 0, 0); push(0, 3, "R7 reload wins"); push(3, 2'b01, "R5 pulse");
        drive(0, 0, 0); push(3, 0, "R5 pulse one cycle"); push(0, 3, "R5 hold");
        // R6 self reload
        wrt(0, 32'h1_0005, 0);
        drive(16'h0020, 0, 0); push(0, 2, "R6 step");
        drive(16'h0020, 0, 0); push(0, 1, "R6 step");
        drive(16'h0020, 0, 0); push(0, 0, "R6 zero");
        drive(16'h0020, 0, 0); push(0, 3, "R6 self reload"); push(3, 2'b01, "R6 pulse");
        // R10 write overrides count
        wrt(2, 7, 16'h0020); push(0, 7, "R10 override"); push(3, 0, "R10 no pulse");
        // R9 chain
        wrt(4, 32'h2_000F, 0); wrt(6, 5, 0); wrt(1, 1, 0); wrt(2, 1, 0);
        drive(16'h0020, 0, 0); push(0, 0, "R9 c0 zero"); push(1, 5, "R9 c1 idle");
        drive(16'h0020, 0, 6); push(0, 1, "R9 c0 reload"); push(1, 4, "R9 chain step");
        push(4, 4, "R9 c1 readback");
        wrt(4, 32'hF, 0);
        drive(16'h0020, 0, 0); push(0, 0, "R9 c0 zero");
        drive(16'h0020, 0, 0); push(0, 1, "R9 c0 reload"); push(1, 4, "R9 unchained hold");
        drive(0, 0, 0);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule